// File: doc/BRIEF.md
# Space Vector Modulation Duty Generator

This block converts a two-axis stationary-frame voltage command into three phase duty values for a three-phase PWM stage. Both command components are signed Q1.15 fractions of the DC bus voltage and arrive as a pair qualified by a valid strobe. The block first expands the pair into three phase voltages. It then finds the largest and smallest of the three and removes their midpoint from every phase. That common-mode shift changes from sample to sample and follows a triangular path over one electrical turn. As a result, the full bus can be used without any sine table or angle arithmetic.

Each shifted phase is then clamped on its own to half of full scale in either direction, which are the 0% and 100% duty points. Because of this clamp, commands beyond the linear circle of radius 1/sqrt(3) bend the output smoothly into trapezoidal over-modulation. At full over-modulation the vector covers the whole hexagon. For every phase the block gives out the clamped signed duty and an unsigned compare value scaled to the PWM period, ready for a carrier comparator. The pipeline takes one sample per clock and has a fixed latency.

Top module: `svm_duty_gen`

## Requirements
- R1: Phase voltages follow A = alpha, B = -alpha/2 + (sqrt(3)/2)·beta, C = -alpha/2 - (sqrt(3)/2)·beta. After the neutral is removed, each duty matches a real-number model within 4 LSB.
- R2: The neutral removed from all phases is the midpoint of the largest and smallest phase value. The largest and smallest output duties therefore sum to within ±1 LSB of zero.
- R3: For command magnitudes up to 0.57 of full scale, the line-to-line differences A-B and B-C of the duties equal those of the unshifted phases within 4 LSB.
- R4: Every duty output stays within [-16384, +16384], which is ±1/2 in Q1.15.
- R5: A command of magnitude 0.7 at angle zero (alpha = 22938, beta = 0) gives exactly duty A = +16384 and duties B = C = -16384. Sweeps at magnitudes 2/3 and 1.0 match the clamped real-number model within 4 LSB.
- R6: Each compare value equals floor((duty + 16384) · PWM_PERIOD / 32768). So duty -16384 gives 0 and duty +16384 gives PWM_PERIOD.
- R7: A sample accepted at a rising edge appears with out_valid exactly 4 rising edges later. A new sample can be accepted on every cycle.
- R8: While rst is high, out_valid is 0, all duties are 0 and all compare values are PWM_PERIOD/2 from the next edge on.
- R9: Cycles with in_valid low produce no output sample, whatever values alpha_in and beta_in carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command pair valid |
| alpha_in | input | DW | Alpha command, signed Q1.15 |
| beta_in | input | DW | Beta command, signed Q1.15 |
| out_valid | output | 1 | Duty and compare outputs valid |
| duty_a | output | DW | Phase A duty, signed, ±16384 = ±1/2 |
| duty_b | output | DW | Phase B duty |
| duty_c | output | DW | Phase C duty |
| cmp_a | output | PW | Phase A compare value, 0 to PWM_PERIOD |
| cmp_b | output | PW | Phase B compare value |
| cmp_c | output | PW | Phase C compare value |

## Verification
On every cycle the assertions check several properties. The clamp range and the compare-value bound hold. The compare values keep the same order as the duties. The registered neutral lies between the smallest and largest phase. The output valid follows the input valid exactly four edges later, and reset drives the compare values to the midpoint. Only the bench scenarios can show the arithmetic itself. They compare against a real-number model in angle sweeps at linear, over-modulated and saturated magnitudes, and they check that line-to-line voltages survive the neutral shift. They also cover the exact clamp values at angle zero and the absence of output for samples that are not valid.

// File: rtl/svm_pkg.sv
package svm_pkg;
  localparam int          NPH         = 3;
  localparam real         SQRT3_HALF  = 0.8660254037844386;
  typedef enum logic [1:0] {PH_A = 2'd0, PH_B = 2'd1, PH_C = 2'd2} phase_e;
endpackage

// File: rtl/svm_clarke.sv
module svm_clarke #(
  parameter int DW = 16,
  parameter int IW = DW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] alpha,
  input  logic signed [DW-1:0] beta,
  output logic                 ph_valid,
  output logic signed [IW-1:0] ph [svm_pkg::NPH]
);
  localparam int PRW = 2 * DW + 1;
  localparam int KQ  = $rtoi(svm_pkg::SQRT3_HALF * (2.0 ** (DW - 1)) + 0.5);
  localparam logic signed [PRW-1:0] K = PRW'(KQ);

  logic signed [IW-1:0]  a_ext, a_half, kb;
  logic signed [PRW-1:0] prod;

  always_comb begin
    a_ext  = IW'(alpha);
    a_half = a_ext >>> 1;
    prod   = PRW'(beta) * K;
    kb     = IW'(prod >>> (DW - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_valid <= 1'b0;
      for (int i = 0; i < svm_pkg::NPH; i++) ph[i] <= '0;
    end else begin
      ph_valid          <= in_valid;
      ph[svm_pkg::PH_A] <= a_ext;
      ph[svm_pkg::PH_B] <= kb - a_half;
      ph[svm_pkg::PH_C] <= -a_half - kb;
    end
  end
endmodule

// File: rtl/svm_neutral.sv
module svm_neutral #(
  parameter int IW = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] v_in [svm_pkg::NPH],
  output logic                 out_valid,
  output logic signed [IW-1:0] v_out [svm_pkg::NPH],
  output logic signed [IW-1:0] neutral
);
  logic signed [IW-1:0] hi01, lo01, vmax, vmin;
  logic signed [IW:0]   span_sum;

  // two compare levels, then midpoint by arithmetic shift
  always_comb begin
    hi01     = (v_in[0] > v_in[1]) ? v_in[0] : v_in[1];
    lo01     = (v_in[0] > v_in[1]) ? v_in[1] : v_in[0];
    vmax     = (hi01 > v_in[2]) ? hi01 : v_in[2];
    vmin     = (lo01 < v_in[2]) ? lo01 : v_in[2];
    span_sum = (IW+1)'(vmax) + (IW+1)'(vmin);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      neutral   <= '0;
      for (int i = 0; i < svm_pkg::NPH; i++) v_out[i] <= '0;
    end else begin
      out_valid <= in_valid;
      neutral   <= IW'(span_sum >>> 1);
      for (int i = 0; i < svm_pkg::NPH; i++) v_out[i] <= v_in[i];
    end
  end
endmodule

// File: rtl/svm_shape.sv
module svm_shape #(
  parameter int DW         = 16,
  parameter int IW         = DW + 2,
  parameter int PW         = 16,
  parameter int PWM_PERIOD = 2500
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] v_in [svm_pkg::NPH],
  input  logic signed [IW-1:0] neutral,
  output logic                 out_valid,
  output logic signed [DW-1:0] duty [svm_pkg::NPH],
  output logic        [PW-1:0] cmp  [svm_pkg::NPH]
);
  localparam int HALF = 2 ** (DW - 2);
  localparam int MW   = DW + PW;
  localparam logic signed [IW:0]   LIM_HI = (IW+1)'(HALF);
  localparam logic signed [IW:0]   LIM_LO = -LIM_HI;
  localparam logic signed [DW-1:0] HALF_D = DW'(HALF);
  localparam logic        [PW-1:0] PER    = PW'(PWM_PERIOD);
  localparam logic        [PW-1:0] MID    = PW'(PWM_PERIOD / 2);

  logic                 sat_valid;
  logic signed [DW-1:0] dsat [svm_pkg::NPH];

  always_ff @(posedge clk) begin
    if (rst) begin
      sat_valid <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      sat_valid <= in_valid;
      out_valid <= sat_valid;
    end
  end

  for (genvar g = 0; g < svm_pkg::NPH; g++) begin : g_phase
    logic signed [IW:0]   shifted, clamped;
    logic        [DW-1:0] offs;
    logic        [MW-1:0] scaled;

    always_comb begin
      shifted = (IW+1)'(v_in[g]) - (IW+1)'(neutral);
      if (shifted > LIM_HI)      clamped = LIM_HI;
      else if (shifted < LIM_LO) clamped = LIM_LO;
      else                       clamped = shifted;
      offs   = dsat[g] + HALF_D;
      scaled = MW'(offs) * MW'(PER);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        dsat[g] <= '0;
        duty[g] <= '0;
        cmp[g]  <= MID;
      end else begin
        dsat[g] <= DW'(clamped);
        duty[g] <= dsat[g];
        cmp[g]  <= PW'(scaled >> (DW - 1));
      end
    end

    assert_duty_clamp_R4: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (duty[g] <= HALF_D && duty[g] >= -HALF_D));

    assert_cmp_bound_R6: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (cmp[g] <= PER));
  end

  assert_neutral_span_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ((neutral <= v_in[0] || neutral <= v_in[1] || neutral <= v_in[2]) &&
                  (neutral >= v_in[0] || neutral >= v_in[1] || neutral >= v_in[2])));

  assert_cmp_order_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && duty[0] >= duty[1]) |-> (cmp[0] >= cmp[1]));
endmodule

// File: rtl/svm_duty_gen.sv
module svm_duty_gen #(
  parameter int DW         = 16,
  parameter int PW         = 16,
  parameter int PWM_PERIOD = 2500
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] alpha_in,
  input  logic signed [DW-1:0] beta_in,
  output logic                 out_valid,
  output logic signed [DW-1:0] duty_a,
  output logic signed [DW-1:0] duty_b,
  output logic signed [DW-1:0] duty_c,
  output logic        [PW-1:0] cmp_a,
  output logic        [PW-1:0] cmp_b,
  output logic        [PW-1:0] cmp_c
);
  localparam int IW      = DW + 2;
  localparam int LATENCY = 4;
  localparam logic [PW-1:0] MID = PW'(PWM_PERIOD / 2);

  logic                 s1_valid, s2_valid;
  logic signed [IW-1:0] s1_ph [svm_pkg::NPH];
  logic signed [IW-1:0] s2_ph [svm_pkg::NPH];
  logic signed [IW-1:0] s2_n;
  logic signed [DW-1:0] d_out [svm_pkg::NPH];
  logic        [PW-1:0] c_out [svm_pkg::NPH];

  svm_clarke #(.DW(DW), .IW(IW)) u_clarke (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .alpha(alpha_in), .beta(beta_in),
    .ph_valid(s1_valid), .ph(s1_ph)
  );

  svm_neutral #(.IW(IW)) u_neutral (
    .clk(clk), .rst(rst), .in_valid(s1_valid), .v_in(s1_ph),
    .out_valid(s2_valid), .v_out(s2_ph), .neutral(s2_n)
  );

  svm_shape #(.DW(DW), .IW(IW), .PW(PW), .PWM_PERIOD(PWM_PERIOD)) u_shape (
    .clk(clk), .rst(rst), .in_valid(s2_valid), .v_in(s2_ph), .neutral(s2_n),
    .out_valid(out_valid), .duty(d_out), .cmp(c_out)
  );

  assign duty_a = d_out[svm_pkg::PH_A];
  assign duty_b = d_out[svm_pkg::PH_B];
  assign duty_c = d_out[svm_pkg::PH_C];
  assign cmp_a  = c_out[svm_pkg::PH_A];
  assign cmp_b  = c_out[svm_pkg::PH_B];
  assign cmp_c  = c_out[svm_pkg::PH_C];

  // edges since reset release, saturating at the pipeline depth
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                    since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'(LATENCY)) |-> (out_valid == $past(in_valid, 4)));

  assert_reset_mid_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && cmp_a == MID && cmp_b == MID && cmp_c == MID));
endmodule

// File: tb/tb_svm_duty_gen.sv
module tb_svm_duty_gen;
  localparam int DW = 16, PW = 16, PER = 2500, HALF = 16384, TOL = 4;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic signed [DW-1:0] alpha_in = '0, beta_in = '0;
  logic out_valid;
  logic signed [DW-1:0] duty_a, duty_b, duty_c;
  logic [PW-1:0] cmp_a, cmp_b, cmp_c;

  svm_duty_gen #(.DW(DW), .PW(PW), .PWM_PERIOD(PER)) dut (.*);

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int ea, eb, ec, lab, lbc, stamp; bit lin, exact; } item_t;
  item_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int q15(input real x);
    int v = rnd(x * 32768.0);
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  function automatic int iabs(input int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic real sat(input real x);
    return (x > 0.5) ? 0.5 : ((x < -0.5) ? -0.5 : x);
  endfunction

  task automatic drive_raw(input int ai, input int bi, input bit lin, input bit exact);
    real a, b, va, vb, vc, mx, mn, nn;
    item_t it;
    a  = ai / 32768.0;
    b  = bi / 32768.0;
    va = a;
    vb = -a / 2.0 + 0.8660254037844386 * b;
    vc = -a / 2.0 - 0.8660254037844386 * b;
    mx = (va > vb) ? va : vb;  mx = (mx > vc) ? mx : vc;
    mn = (va < vb) ? va : vb;  mn = (mn < vc) ? mn : vc;
    nn = (mx + mn) / 2.0;
    it.ea = rnd(sat(va - nn) * 32768.0);
    it.eb = rnd(sat(vb - nn) * 32768.0);
    it.ec = rnd(sat(vc - nn) * 32768.0);
    it.lab = rnd((va - vb) * 32768.0);
    it.lbc = rnd((vb - vc) * 32768.0);
    it.lin = lin;
    it.exact = exact;
    @(posedge clk); #1;
    alpha_in = DW'(ai);
    beta_in  = DW'(bi);
    in_valid = 1'b1;
    it.stamp = cyc + 4;
    sb.push_back(it);
  endtask

  task automatic drive(input real mag, input real deg);
    drive_raw(q15(mag * $cos(deg * PI / 180.0)), q15(mag * $sin(deg * PI / 180.0)),
              mag <= 0.57, 1'b0);
  endtask

  // R9: idle cycles carry large junk on the data inputs
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
      alpha_in = DW'(32767 - 1000 * i);
      beta_in  = DW'(-32768 + 700 * i);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R9", "output without accepted sample", 1, 0);
        end else begin
          item_t it;
          int da, db, dc, mx, mn;
          it = sb.pop_front();
          da = int'(duty_a); db = int'(duty_b); dc = int'(duty_c);
          check(cyc == it.stamp, "R7", "output cycle", cyc, it.stamp);
          if (it.exact) begin
            check(da == it.ea, "R5", "exact duty A", da, it.ea);
            check(db == it.eb, "R5", "exact duty B", db, it.eb);
            check(dc == it.ec, "R5", "exact duty C", dc, it.ec);
          end
          check(iabs(da - it.ea) <= TOL, "R1", "duty A vs model", da, it.ea);
          check(iabs(db - it.eb) <= TOL, "R1", "duty B vs model", db, it.eb);
          check(iabs(dc - it.ec) <= TOL, "R1", "duty C vs model", dc, it.ec);
          check(da <= HALF && da >= -HALF && db <= HALF && db >= -HALF &&
                dc <= HALF && dc >= -HALF, "R4", "duty range", da, HALF);
          mx = (da > db) ? da : db;  mx = (mx > dc) ? mx : dc;
          mn = (da < db) ? da : db;  mn = (mn < dc) ? mn : dc;
          check(iabs(mx + mn) <= 1, "R2", "max+min of duties", mx + mn, 0);
          if (it.lin) begin
            check(iabs((da - db) - it.lab) <= TOL, "R3", "line A-B", da - db, it.lab);
            check(iabs((db - dc) - it.lbc) <= TOL, "R3", "line B-C", db - dc, it.lbc);
          end
          check(int'(cmp_a) == ((da + HALF) * PER) / 32768, "R6", "cmp A", int'(cmp_a), ((da + HALF) * PER) / 32768);
          check(int'(cmp_b) == ((db + HALF) * PER) / 32768, "R6", "cmp B", int'(cmp_b), ((db + HALF) * PER) / 32768);
          check(int'(cmp_c) == ((dc + HALF) * PER) / 32768, "R6", "cmp C", int'(cmp_c), ((dc + HALF) * PER) / 32768);
        end
      end else if (sb.size() > 0 && sb[0].stamp < cyc) begin
        check(1'b0, "R7", "missing output", cyc, sb[0].stamp);
        void'(sb.pop_front());
      end
    end
  end

  task automatic reset_check();
    check(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
    check(duty_a == 0 && duty_b == 0 && duty_c == 0, "R8", "duty A in reset", int'(duty_a), 0);
    check(int'(cmp_a) == PER / 2 && int'(cmp_b) == PER / 2 && int'(cmp_c) == PER / 2,
          "R8", "cmp A in reset", int'(cmp_a), PER / 2);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog: actual cycle %0d expected below %0d", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    reset_check();
    @(posedge clk); #1;
    rst = 1'b0;
    idle(3);

    // linear region, back-to-back (R1, R3, R7)
    for (int k = 0; k < 36; k++) drive(0.57, 10.0 * k);
    idle(2);
    // small magnitude with gaps and junk on idle cycles (R9)
    for (int k = 0; k < 12; k++) begin
      drive(0.3, 30.0 * k + 7.0);
      idle(k % 3);
    end
    // exact clamp point (R5)
    drive_raw(22938, 0, 1'b0, 1'b1);
    idle(1);
    // over-modulation at 2/3 and at full scale (R5, R4)
    for (int k = 0; k < 24; k++) drive(2.0 / 3.0, 15.0 * k);
    for (int k = 0; k < 24; k++) drive(1.0, 15.0 * k + 3.0);
    // extreme corners (R4, R6)
    drive_raw(-32768, -32768, 1'b0, 1'b0);
    drive_raw(32767, -32768, 1'b0, 1'b0);
    drive_raw(0, 0, 1'b1, 1'b0);
    idle(10);
    @(negedge clk);
    check(sb.size() == 0, "R7", "scoreboard drained", sb.size(), 0);

    // reset in the middle of a stream (R8)
    drive(0.5, 45.0);
    drive(0.5, 90.0);
    @(posedge clk); #1;
    rst = 1'b1;
    in_valid = 1'b0;
    sb.delete();
    @(posedge clk);
    @(negedge clk);
    reset_check();
    repeat (6) @(negedge clk);
    check(out_valid == 1'b0, "R8", "no output after reset", int'(out_valid), 0);
    finish_run();
  end
endmodule